// File: doc/BRIEF.md
# Inter-Task Miss Classifier

This block watches the last-level cache lookups of a shared chip and, on behalf of one owning task, decides which of that task's misses were caused by other tasks. It keeps a shadow tag directory holding the tags that the owning task would have in the cache if it ran alone. Only the owning task's accesses update this directory. When a lookup by the owning task misses in the real cache but hits in the shadow copy, the line must have been evicted by another task. The block then raises a one-cycle event and adds that miss's latency to a cycle count that the accounting logic subtracts from the task's charged CPU time.

The shadow copy covers a small subset of the cache sets so that its storage stays small. The subset comes from a scrambled mapping of the set index, not from a regular stride, so periodic access patterns do not line up with it. Each sampled set keeps the same number of ways as the real cache and uses true LRU replacement.

Top module: `itm_classifier`

## Requirements
- R1: After reset, `itm_pulse` is 0, `excl_cycles` is 0, and every shadow set is empty. The first owner access to any sampled set therefore never flags an inter-task miss.
- R2: A valid access with `acc_task` equal to the owner id, to a sampled set, whose tag is present in the shadow set and with `acc_hit`=0, drives `itm_pulse` to 1 in the cycle after that access. In every other case `itm_pulse` is 0.
- R3: An access with `acc_hit`=1 never flags an event. An owner access to a sampled set still updates the shadow LRU state.
- R4: Accesses from any task other than the owner leave the shadow state unchanged and never flag an event.
- R5: Owner accesses to sets that are not sampled leave the shadow state unchanged and never flag an event.
- R6: Set s is sampled when p = ((s*SAMP_MULT) mod 2^SET_W) XOR SAMP_SEED is less than SAMPLES. Its shadow slot is p. SAMP_MULT is odd, so the mapping is a permutation.
- R7: Each shadow set holds WAYS tags under true LRU. A shadow hit makes the tag most recent. A shadow miss inserts the tag in place of the least recently used entry, so the tag that has gone longest without an access is the one dropped.
- R8: On an event, `miss_lat` is added to `excl_cycles` in the same cycle that `itm_pulse` rises. The sum saturates at 2^CNT_W-1.
- R9: `excl_cycles` does not change in any cycle without an event, whatever the value on `miss_lat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A cache lookup is presented this cycle |
| acc_task | input | TASK_W | Task issuing the lookup |
| acc_set | input | SET_W | Cache set index of the lookup |
| acc_tag | input | TAG_W | Tag of the lookup |
| acc_hit | input | 1 | Real cache result: 1 = hit |
| miss_lat | input | LAT_W | Stall cycles of this lookup's miss |
| itm_pulse | output | 1 | One-cycle inter-task miss event |
| excl_cycles | output | CNT_W | Saturating count of cycles to exclude |

## Verification
The bench targets the LRU order. It fills a set, touches its oldest entry and then inserts one more tag. A design that evicts in fill order, or that does not promote on a hit, flags the wrong line on the accesses that follow. It interleaves other tasks' misses with the owner's accesses to the same set: if foreign accesses leaked into the shadow state, the owner's later real miss would go unflagged. It sweeps every set index once, so a wrong scramble or slot selection shows up as events on unsampled sets. It drives the counter into saturation, where a design that wraps would report a small count.

// File: rtl/itm_pkg.sv
package itm_pkg;
  // How one lookup is classified against the shadow directory.
  typedef enum logic [1:0] {
    AC_IGNORED    = 2'd0,  // not the owner, or set not sampled
    AC_SHD_MISS   = 2'd1,  // tracked, shadow miss (cold or capacity)
    AC_SHD_HIT    = 2'd2,  // tracked, shadow hit, real hit
    AC_INTER_TASK = 2'd3   // tracked, shadow hit, real miss
  } acc_class_e;
endpackage

// File: rtl/itm_sample_map.sv
module itm_sample_map #(
  parameter int SET_W     = 8,
  parameter int SAMPLES   = 16,
  parameter int SAMP_MULT = 157,
  parameter int SAMP_SEED = 90,
  localparam int IDX_W    = $clog2(SAMPLES)
) (
  input  logic [SET_W-1:0] set_idx,
  output logic             sampled,
  output logic [IDX_W-1:0] slot
);
  // Odd multiplier modulo 2^SET_W followed by XOR: a bijection of set indices.
  function automatic logic [SET_W-1:0] scramble(input logic [SET_W-1:0] s);
    logic [SET_W-1:0] m;
    logic [SET_W-1:0] k;
    m = SAMP_MULT[SET_W-1:0];
    k = SAMP_SEED[SET_W-1:0];
    return (s * m) ^ k;
  endfunction

  logic [SET_W-1:0] perm;

  always_comb begin
    perm    = scramble(set_idx);
    sampled = (int'(perm) < SAMPLES);
    slot    = perm[IDX_W-1:0];
  end
endmodule

// File: rtl/itm_shadow_dir.sv
module itm_shadow_dir #(
  parameter int SAMPLES = 16,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 10,
  localparam int IDX_W  = $clog2(SAMPLES),
  localparam int AGE_W  = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [IDX_W-1:0] slot,
  input  logic [TAG_W-1:0] tag,
  output logic             shd_hit
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [TAG_W-1:0] tag_q [SAMPLES][WAYS];
  logic             vld_q [SAMPLES][WAYS];
  logic [AGE_W-1:0] age_q [SAMPLES][WAYS];

  logic [WAYS-1:0]  match;
  logic [AGE_W-1:0] hit_age;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[slot][w] && (tag_q[slot][w] == tag);
  end

  always_comb begin
    shd_hit = |match;
    hit_age = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_age = age_q[slot][w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SAMPLES; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= AGE_W'(w);
        end
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++) begin
        if (shd_hit) begin
          if (match[w])                     age_q[slot][w] <= '0;
          else if (age_q[slot][w] < hit_age) age_q[slot][w] <= age_q[slot][w] + AGE_W'(1);
        end else if (age_q[slot][w] == OLDEST) begin
          age_q[slot][w] <= '0;
          tag_q[slot][w] <= tag;
          vld_q[slot][w] <= 1'b1;
        end else begin
          age_q[slot][w] <= age_q[slot][w] + AGE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/itm_penalty_acc.sv
module itm_penalty_acc #(
  parameter int LAT_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add,
  input  logic [LAT_W-1:0] lat,
  output logic [CNT_W-1:0] cnt
);
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                input logic [LAT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W + 1 - LAT_W){1'b0}}, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (add) cnt <= sat_add(cnt, lat);
  end
endmodule

// File: rtl/itm_classifier.sv
module itm_classifier
  import itm_pkg::*;
#(
  parameter int TASK_W    = 2,
  parameter int OWNER     = 0,
  parameter int SET_W     = 8,
  parameter int TAG_W     = 10,
  parameter int WAYS      = 4,
  parameter int SAMPLES   = 16,
  parameter int LAT_W     = 8,
  parameter int CNT_W     = 12,
  parameter int SAMP_MULT = 157,
  parameter int SAMP_SEED = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [TASK_W-1:0] acc_task,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic              acc_hit,
  input  logic [LAT_W-1:0]  miss_lat,
  output logic              itm_pulse,
  output logic [CNT_W-1:0]  excl_cycles
);
  localparam int IDX_W = $clog2(SAMPLES);

  logic             own_acc;
  logic             set_sampled;
  logic [IDX_W-1:0] set_slot;
  logic             tracked;
  logic             shd_hit;
  acc_class_e       acc_class;
  logic             itm_evt;

  assign own_acc = acc_valid && (acc_task == TASK_W'(OWNER));
  assign tracked = own_acc && set_sampled;

  itm_sample_map #(
    .SET_W(SET_W), .SAMPLES(SAMPLES), .SAMP_MULT(SAMP_MULT), .SAMP_SEED(SAMP_SEED)
  ) map_i (
    .set_idx(acc_set), .sampled(set_sampled), .slot(set_slot)
  );

  itm_shadow_dir #(
    .SAMPLES(SAMPLES), .WAYS(WAYS), .TAG_W(TAG_W)
  ) dir_i (
    .clk(clk), .rst_n(rst_n), .upd(tracked), .slot(set_slot), .tag(acc_tag),
    .shd_hit(shd_hit)
  );

  always_comb begin
    if (!tracked)     acc_class = AC_IGNORED;
    else if (!shd_hit) acc_class = AC_SHD_MISS;
    else if (acc_hit)  acc_class = AC_SHD_HIT;
    else               acc_class = AC_INTER_TASK;
  end

  assign itm_evt = (acc_class == AC_INTER_TASK);

  itm_penalty_acc #(
    .LAT_W(LAT_W), .CNT_W(CNT_W)
  ) acc_i (
    .clk(clk), .rst_n(rst_n), .add(itm_evt), .lat(miss_lat), .cnt(excl_cycles)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) itm_pulse <= 1'b0;
    else        itm_pulse <= itm_evt;
  end
endmodule

// File: rtl/itm_classifier_chk.sv
module itm_classifier_chk #(
  parameter int TASK_W = 2,
  parameter int OWNER  = 0,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [TASK_W-1:0] acc_task,
  input logic              acc_hit,
  input logic              set_sampled,
  input logic              itm_pulse,
  input logic [CNT_W-1:0]  excl_cycles
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  owner_miss_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itm_pulse |-> $past(acc_valid && acc_task == TASK_W'(OWNER) && !acc_hit));

  // R3
  real_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=> !itm_pulse);

  // R4
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_task != TASK_W'(OWNER)) |=> !itm_pulse);

  // R5
  unsampled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !set_sampled) |=> !itm_pulse);

  // R8
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (excl_cycles >= $past(excl_cycles)));

  // R8
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (excl_cycles == CNT_MAX) |=> (excl_cycles == CNT_MAX));

  // R9
  cnt_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (excl_cycles != $past(excl_cycles)) |-> itm_pulse);
endmodule

bind itm_classifier itm_classifier_chk #(
  .TASK_W(TASK_W), .OWNER(OWNER), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_task(acc_task),
  .acc_hit(acc_hit), .set_sampled(set_sampled), .itm_pulse(itm_pulse),
  .excl_cycles(excl_cycles)
);

// File: tb/itm_classifier_tb_top.sv
module itm_classifier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TASK_W = 2, OWNER = 0, SET_W = 8, TAG_W = 10, WAYS = 4;
  localparam int SAMPLES = 16, LAT_W = 8, CNT_W = 12, SAMP_MULT = 157, SAMP_SEED = 90;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  typedef logic [TAG_W-1:0] tag_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0;
  logic [TASK_W-1:0] acc_task = '0;
  logic [SET_W-1:0]  acc_set = '0;
  logic [TAG_W-1:0]  acc_tag = '0;
  logic              acc_hit = 1'b0;
  logic [LAT_W-1:0]  miss_lat = '0;
  logic              itm_pulse;
  logic [CNT_W-1:0]  excl_cycles;

  int   n_chk = 0, n_err = 0;
  int   exp_cnt = 0;
  bit   exp_itm = 0;
  tag_t mdl [SAMPLES][$];   // per slot: front = most recent
  int   s_a = -1, s_b = -1, s_u = -1;

  itm_classifier #(
    .TASK_W(TASK_W), .OWNER(OWNER), .SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS),
    .SAMPLES(SAMPLES), .LAT_W(LAT_W), .CNT_W(CNT_W),
    .SAMP_MULT(SAMP_MULT), .SAMP_SEED(SAMP_SEED)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_task(acc_task),
    .acc_set(acc_set), .acc_tag(acc_tag), .acc_hit(acc_hit), .miss_lat(miss_lat),
    .itm_pulse(itm_pulse), .excl_cycles(excl_cycles)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Sampling rule restated from R6 with plain integer arithmetic.
  function automatic int slot_of(int s);
    int p;
    p = ((s * SAMP_MULT) % (1 << SET_W)) ^ SAMP_SEED;
    return (p < SAMPLES) ? p : -1;
  endfunction

  task automatic check(bit ok, string req, int act, int expv, string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // One access: drive at a falling edge, run the model, compare at the next falling edge.
  task automatic step(bit v, int t, int s, int tg, bit h, int lat, string req);
    int sl, idx;
    acc_valid = v; acc_task = TASK_W'(t); acc_set = SET_W'(s);
    acc_tag = TAG_W'(tg); acc_hit = h; miss_lat = LAT_W'(lat);
    exp_itm = 0;
    sl = slot_of(s);
    if (v && t == OWNER && sl >= 0) begin
      idx = -1;
      foreach (mdl[sl][i]) if (mdl[sl][i] == tag_t'(tg)) idx = i;
      if (idx >= 0) begin
        exp_itm = !h;
        mdl[sl].delete(idx);
      end else if (mdl[sl].size() == WAYS) begin
        void'(mdl[sl].pop_back());
      end
      mdl[sl].push_front(tag_t'(tg));
      if (exp_itm) exp_cnt = (exp_cnt + lat > CNT_MAX) ? CNT_MAX : exp_cnt + lat;
    end
    @(negedge clk);
    check(itm_pulse == exp_itm, req, int'(itm_pulse), int'(exp_itm), "itm_pulse");
    check(int'(excl_cycles) == exp_cnt, req, int'(excl_cycles), exp_cnt, "excl_cycles");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int s = 0; s < (1 << SET_W); s++) begin
      if (slot_of(s) >= 0) begin
        if (s_a < 0) s_a = s;
        else if (s_b < 0) s_b = s;
      end else if (s_u < 0) s_u = s;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(itm_pulse == 1'b0, "R1", int'(itm_pulse), 0, "itm_pulse after reset");
    check(excl_cycles == '0, "R1", int'(excl_cycles), 0, "excl_cycles after reset");
    step(1, OWNER, s_a, 1, 0, 30, "R1");   // cold shadow: no event
    // R2: owner refetch after a foreign eviction
    step(1, OWNER, s_a, 1, 0, 20, "R2");
    // R3: real hit is not flagged
    step(1, OWNER, s_a, 1, 1, 40, "R3");
    // R4: other tasks thrash the set; the owner's shadow keeps tag 1
    for (int k = 2; k < 8; k++) step(1, 1 + (k % 3), s_a, k, 0, 50, "R4");
    step(1, OWNER, s_a, 1, 0, 7, "R4");
    // R5: unsampled set never classifies
    step(1, OWNER, s_u, 9, 0, 60, "R5");
    step(1, OWNER, s_u, 9, 0, 60, "R5");
    // R9: latency presented without an event
    step(0, OWNER, s_a, 1, 0, 255, "R9");
    step(1, 2, s_a, 1, 0, 255, "R9");
    // R7: LRU order
    for (int k = 10; k < 14; k++) step(1, OWNER, s_b, k, 0, 1, "R7");
    step(1, OWNER, s_b, 10, 1, 1, "R7");
    step(1, OWNER, s_b, 14, 0, 1, "R7");   // evicts 11
    step(1, OWNER, s_b, 10, 0, 3, "R7");   // flagged
    step(1, OWNER, s_b, 11, 0, 3, "R7");   // not flagged, evicts 12
    step(1, OWNER, s_b, 12, 0, 3, "R7");   // not flagged
    // R6: sweep every set, touch twice
    for (int s = 0; s < (1 << SET_W); s++) begin
      step(1, OWNER, s, 1000, 0, 2, "R6");
      step(1, OWNER, s, 1000, 0, 2, "R6");
    end
    // R8: saturation
    for (int k = 0; k < 20; k++) step(1, OWNER, s_b, 14, 0, 255, "R8");
    // Mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      int ss;
      case ($urandom_range(0, 2))
        0: ss = s_a;
        1: ss = s_b;
        default: ss = s_u;
      endcase
      step($urandom_range(0, 7) != 0, $urandom_range(0, 3), ss,
           $urandom_range(0, 6), $urandom_range(0, 1) == 1, $urandom_range(0, 255), "R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule